// File: doc/BRIEF.md
# Hazard-Blocking Three-Stage Register ALU

This block is a small pipelined arithmetic unit with four 3-bit architectural registers. On every clock step it takes one operation: a 2-bit opcode, two source register indices and one destination index. The operation then passes through three stages. The first stage captures the source operands, the second computes the sum or difference, and the third commits the value to the destination register.

Hazards are never forwarded and the issuer is never stalled. An operation is screened on entry and becomes a NOP bubble if it names any register that an operation still in the pipeline names, or if its opcode is illegal. This screening makes the latched pipeline behave exactly like an atomic model, in which each operation reads and writes the register file in one step. A parameter selects that atomic model in place of the latched datapath, so both builds can run side by side.

Every register can be read at the ports at all times. A status output shows the opcode held in each stage.

Top module: `hna_alu`

## Requirements
- R1: During and right after reset, the registers hold the `INIT_VALS` parameter (all zero by default), and every stage reports opcode 2'b00. `reg_view` places register r at bits [3r+2:3r].
- R2: Opcode 2'b01 (ADD) writes (srcA + srcB) mod 8 to dst. The register changes on the third rising edge, counting the edge that admits the operation as the first. No other register changes on that edge.
- R3: Opcode 2'b10 (SUB) writes (srcA - srcB) mod 8 to dst, with the same latency as ADD.
- R4: Opcode 2'b00 (NOP) changes no register. On any edge where stage 2 does not hold an arithmetic operation, `reg_view` stays stable.
- R5: Opcode 2'b11 is illegal and is admitted as a NOP. It leaves the registers unchanged, and no stage ever reports 2'b11.
- R6: Take the set {srcA, srcB, dst} of an incoming ADD or SUB. If it shares any index with the set of an arithmetic operation held in any of the three stages, the incoming operation is admitted as a NOP. A source shared with another operation's source also counts.
- R7: `stage_opc[1:0]`, `[3:2]` and `[5:4]` report stages 1, 2 and 3. On every edge, stage 2 takes the old stage 1 and stage 3 takes the old stage 2.
- R8: An operation admitted on edge k blocks any overlapping operation offered on edges k+1, k+2 and k+3. An overlapping operation offered on edge k+4 is admitted.
- R9: A build with `ABSTRACT=1` executes each operation whole in the step that moves it into stage 3. For the same input stream, its `reg_view` and `stage_opc` match the latched build on every cycle.
- R10: An ADD or SUB that overlaps nothing in flight is admitted on the next edge, so operations on disjoint registers enter on consecutive steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 2 | Opcode of the offered operation |
| op_src_a | input | 2 | First source register index |
| op_src_b | input | 2 | Second source register index |
| op_dst | input | 2 | Destination register index |
| reg_view | output | 12 | All four registers, register r at bits [3r+2:3r] |
| stage_opc | output | 6 | Opcode held in stages 1, 2 and 3 |

## Verification
The bench builds two copies with `INIT_VALS` set to 1, 2, 3 and 5 for r0 to r3, one latched and one with `ABSTRACT=1`. Because the registers start from distinct non-zero values, ADD and SUB can reach every 3-bit value, including both wrap directions. Sweeps of every opcode and index combination, in three orderings, then drive both copies through many overlapping and disjoint pairings. Both copies are compared against an arithmetic model every step, and directed sequences pin down the four-step reuse distance and the back-to-back admission of disjoint operations.

// File: rtl/hna_pkg.sv
package hna_pkg;
  parameter int unsigned HNA_REGS   = 4;
  parameter int unsigned HNA_DATA_W = 3;
  parameter int unsigned HNA_STAGES = 3;
  localparam int unsigned HNA_IDX_W = $clog2(HNA_REGS);
  localparam int unsigned HNA_OPC_W = 2;

  typedef logic [HNA_OPC_W-1:0]  opc_t;
  typedef logic [HNA_IDX_W-1:0]  ridx_t;
  typedef logic [HNA_DATA_W-1:0] word_t;

  localparam opc_t OPC_NOP = 2'b00;
  localparam opc_t OPC_ADD = 2'b01;
  localparam opc_t OPC_SUB = 2'b10;

  typedef struct packed {
    opc_t  opc;
    ridx_t sa;
    ridx_t sb;
    ridx_t dst;
  } hna_op_t;

  localparam hna_op_t HNA_BUBBLE = '0;

  function automatic logic opc_legal(opc_t c);
    return (c == OPC_NOP) || (c == OPC_ADD) || (c == OPC_SUB);
  endfunction

  function automatic logic opc_arith(opc_t c);
    return (c == OPC_ADD) || (c == OPC_SUB);
  endfunction

  function automatic logic names_reg(hna_op_t o, ridx_t r);
    return opc_arith(o.opc) && ((o.sa == r) || (o.sb == r) || (o.dst == r));
  endfunction

  function automatic logic ops_overlap(hna_op_t x, hna_op_t y);
    return opc_arith(x.opc) &&
           (names_reg(y, x.sa) || names_reg(y, x.sb) || names_reg(y, x.dst));
  endfunction

  function automatic word_t alu_eval(opc_t c, word_t x, word_t y);
    word_t r;
    case (c)
      OPC_ADD: r = x + y;
      OPC_SUB: r = x - y;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hna_issue_filter.sv
module hna_issue_filter
  import hna_pkg::*;
(
  input  hna_op_t                  req,
  input  hna_op_t [HNA_STAGES-1:0] live,
  output hna_op_t                  admit,
  output logic                     hazard_hit,
  output logic                     bad_opcode
);
  logic [HNA_STAGES-1:0] hit_vec;

  for (genvar g = 0; g < HNA_STAGES; g++) begin : g_probe
    assign hit_vec[g] = ops_overlap(req, live[g]);
  end

  assign bad_opcode = !opc_legal(req.opc);
  assign hazard_hit = |hit_vec;
  assign admit      = (bad_opcode || hazard_hit || !opc_arith(req.opc)) ? HNA_BUBBLE : req;
endmodule

// File: rtl/hna_stage_chain.sv
module hna_stage_chain
  import hna_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  hna_op_t                  admit,
  output hna_op_t [HNA_STAGES-1:0] stg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= admit;
      for (int s = 1; s < HNA_STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end
endmodule

// File: rtl/hna_dp_latched.sv
module hna_dp_latched
  import hna_pkg::*;
#(
  parameter logic [HNA_REGS*HNA_DATA_W-1:0] INIT_VALS = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ridx_t                  load_sa,
  input  ridx_t                  load_sb,
  input  opc_t                   calc_opc,
  input  opc_t                   wb_opc,
  input  ridx_t                  wb_dst,
  output word_t [HNA_REGS-1:0]   regs
);
  word_t in1, in2, result;
  logic  wb_fire;

  assign wb_fire = opc_arith(wb_opc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in1    <= '0;
      in2    <= '0;
      result <= '0;
    end else begin
      in1    <= regs[load_sa];
      in2    <= regs[load_sb];
      result <= alu_eval(calc_opc, in1, in2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= INIT_VALS;
    end else if (wb_fire) begin
      regs[wb_dst] <= result;
    end
  end
endmodule

// File: rtl/hna_dp_direct.sv
module hna_dp_direct
  import hna_pkg::*;
#(
  parameter logic [HNA_REGS*HNA_DATA_W-1:0] INIT_VALS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  hna_op_t              wb_op,
  output word_t [HNA_REGS-1:0] regs
);
  logic  exec_fire;
  word_t exec_val;

  assign exec_fire = opc_arith(wb_op.opc);
  assign exec_val  = alu_eval(wb_op.opc, regs[wb_op.sa], regs[wb_op.sb]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= INIT_VALS;
    end else if (exec_fire) begin
      regs[wb_op.dst] <= exec_val;
    end
  end
endmodule

// File: rtl/hna_alu.sv
module hna_alu
  import hna_pkg::*;
#(
  parameter bit                             ABSTRACT  = 1'b0,
  parameter logic [HNA_REGS*HNA_DATA_W-1:0] INIT_VALS = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [HNA_OPC_W-1:0]             op_code,
  input  logic [HNA_IDX_W-1:0]             op_src_a,
  input  logic [HNA_IDX_W-1:0]             op_src_b,
  input  logic [HNA_IDX_W-1:0]             op_dst,
  output logic [HNA_REGS*HNA_DATA_W-1:0]   reg_view,
  output logic [HNA_STAGES*HNA_OPC_W-1:0]  stage_opc
);
  hna_op_t                  req;
  hna_op_t                  admit;
  hna_op_t [HNA_STAGES-1:0] stg;
  word_t   [HNA_REGS-1:0]   regs;
  logic                     hazard_hit;
  logic                     bad_opcode;

  assign req = '{opc: op_code, sa: op_src_a, sb: op_src_b, dst: op_dst};

  hna_issue_filter u_filter (
    .req        (req),
    .live       (stg),
    .admit      (admit),
    .hazard_hit (hazard_hit),
    .bad_opcode (bad_opcode)
  );

  hna_stage_chain u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .admit (admit),
    .stg   (stg)
  );

  if (ABSTRACT) begin : g_direct
    hna_dp_direct #(.INIT_VALS(INIT_VALS)) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .wb_op (stg[1]),
      .regs  (regs)
    );
  end else begin : g_latched
    hna_dp_latched #(.INIT_VALS(INIT_VALS)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_sa  (admit.sa),
      .load_sb  (admit.sb),
      .calc_opc (stg[0].opc),
      .wb_opc   (stg[1].opc),
      .wb_dst   (stg[1].dst),
      .regs     (regs)
    );
  end

  assign reg_view = regs;

  for (genvar g = 0; g < HNA_STAGES; g++) begin : g_status
    assign stage_opc[g*HNA_OPC_W +: HNA_OPC_W] = stg[g].opc;
  end
endmodule

// File: rtl/hna_alu_chk.sv
module hna_alu_chk
  import hna_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic [HNA_OPC_W-1:0]           op_code,
  input logic [HNA_REGS*HNA_DATA_W-1:0] reg_view,
  input hna_op_t [HNA_STAGES-1:0]       stg,
  input logic                           hazard_hit,
  input logic                           bad_opcode
);
  // R7: every stage advances by one on each edge
  p_stage_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stg[1] == $past(stg[0])) && (stg[2] == $past(stg[1])));

  // R5: an illegal opcode enters as a bubble
  p_bad_opcode_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode |=> (stg[0].opc == OPC_NOP));

  // R5: no stage ever carries the illegal code
  p_legal_stages_r5: assert property (@(posedge clk) disable iff (!rst_n)
    opc_legal(stg[0].opc) && opc_legal(stg[1].opc) && opc_legal(stg[2].opc));

  // R6: a detected hazard turns the entry into a bubble
  p_hazard_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_hit |=> (stg[0] == HNA_BUBBLE));

  // R6: operations in flight never share a register
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ops_overlap(stg[0], stg[1]) && !ops_overlap(stg[0], stg[2]) &&
    !ops_overlap(stg[1], stg[2]));

  // R4: without an arithmetic op in stage 2, registers hold
  p_idle_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !opc_arith(stg[1].opc) |=> $stable(reg_view));

  // R10: a clean arithmetic offer is admitted unchanged
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_arith(op_code) && !hazard_hit) |=> (stg[0].opc == $past(op_code)));

  // R2: writeback touches only its destination
  for (genvar r = 0; r < HNA_REGS; r++) begin : g_hold
    p_others_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (opc_arith(stg[1].opc) && (stg[1].dst != ridx_t'(r))) |=>
        $stable(reg_view[r*HNA_DATA_W +: HNA_DATA_W]));
  end
endmodule

bind hna_alu hna_alu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_code    (op_code),
  .reg_view   (reg_view),
  .stg        (stg),
  .hazard_hit (hazard_hit),
  .bad_opcode (bad_opcode)
);

// File: tb/tb_hna_alu.sv
module tb_hna_alu;
  localparam logic [11:0] INITS = {3'd5, 3'd3, 3'd2, 3'd1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_code = '0;
  logic [1:0]  op_src_a = '0;
  logic [1:0]  op_src_b = '0;
  logic [1:0]  op_dst = '0;
  logic [11:0] reg_view, reg_view_abs;
  logic [5:0]  stage_opc, stage_opc_abs;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_reg [4];
  int m_opc [3];
  int m_sa [3];
  int m_sb [3];
  int m_dst [3];

  always #4 clk = ~clk;

  hna_alu #(.ABSTRACT(1'b0), .INIT_VALS(INITS)) dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_src_a(op_src_a),
    .op_src_b(op_src_b), .op_dst(op_dst), .reg_view(reg_view), .stage_opc(stage_opc));

  hna_alu #(.ABSTRACT(1'b1), .INIT_VALS(INITS)) dut_abs (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_src_a(op_src_a),
    .op_src_b(op_src_b), .op_dst(op_dst), .reg_view(reg_view_abs), .stage_opc(stage_opc_abs));

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int do_math(int c, int x, int y);
    if (c == 1) return (x + y) % 8;
    return (x + 8 - y) % 8;
  endfunction

  function automatic int reg_of(int r);
    return int'(reg_view[r*3 +: 3]);
  endfunction

  task automatic issue(input int c, input int a, input int b, input int d);
    int  exp_regs;
    int  exp_stg;
    bit  ok;
    @(negedge clk);
    op_code  = c[1:0];
    op_src_a = a[1:0];
    op_src_b = b[1:0];
    op_dst   = d[1:0];
    ok = (c == 1) || (c == 2);
    for (int k = 0; k < 3; k++) begin
      if (m_opc[k] == 1 || m_opc[k] == 2) begin
        if (a == m_sa[k] || a == m_sb[k] || a == m_dst[k] ||
            b == m_sa[k] || b == m_sb[k] || b == m_dst[k] ||
            d == m_sa[k] || d == m_sb[k] || d == m_dst[k]) ok = 1'b0;
      end
    end
    if (m_opc[1] == 1 || m_opc[1] == 2)
      m_reg[m_dst[1]] = do_math(m_opc[1], m_reg[m_sa[1]], m_reg[m_sb[1]]);
    for (int k = 2; k > 0; k--) begin
      m_opc[k] = m_opc[k-1]; m_sa[k] = m_sa[k-1];
      m_sb[k] = m_sb[k-1];   m_dst[k] = m_dst[k-1];
    end
    m_opc[0] = ok ? c : 0;
    m_sa[0]  = ok ? a : 0;
    m_sb[0]  = ok ? b : 0;
    m_dst[0] = ok ? d : 0;
    @(posedge clk);
    #2;
    exp_regs = 0;
    for (int r = 0; r < 4; r++) exp_regs = exp_regs | (m_reg[r] << (3 * r));
    exp_stg = m_opc[0] | (m_opc[1] << 2) | (m_opc[2] << 4);
    chk("R9 latched regs vs model", int'(reg_view), exp_regs);
    chk("R9 abstract regs vs model", int'(reg_view_abs), exp_regs);
    chk("R9 latched stages vs model", int'(stage_opc), exp_stg);
    chk("R9 abstract stages vs model", int'(stage_opc_abs), exp_stg);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int snap;
    m_reg[0] = 1; m_reg[1] = 2; m_reg[2] = 3; m_reg[3] = 5;
    for (int k = 0; k < 3; k++) begin
      m_opc[k] = 0; m_sa[k] = 0; m_sb[k] = 0; m_dst[k] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    chk("R1 regs in reset", int'(reg_view), 'o5321);
    chk("R1 stages in reset", int'(stage_opc), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 regs after release", int'(reg_view_abs), 'o5321);
    chk("R1 stages after release", int'(stage_opc_abs), 0);

    // R2: r3 = r3 + r2 = 5 + 3 wraps to 0, lands on the third edge
    issue(1, 3, 2, 3);
    chk("R7 stage1 holds ADD", int'(stage_opc[1:0]), 1);
    chk("R2 r3 unchanged after edge 1", reg_of(3), 5);
    issue(0, 0, 0, 0);
    chk("R7 stage2 holds ADD", int'(stage_opc[3:2]), 1);
    chk("R2 r3 unchanged after edge 2", reg_of(3), 5);
    issue(0, 0, 0, 0);
    chk("R7 stage3 holds ADD", int'(stage_opc[5:4]), 1);
    chk("R2 r3 wraps 5+3", reg_of(3), 0);
    flush();

    // R3: r1 = r0 - r2 = 1 - 3 wraps to 6
    issue(2, 0, 2, 1);
    flush();
    chk("R3 r1 wraps 1-3", reg_of(1), 6);

    // R5: illegal opcode admitted as bubble
    issue(3, 0, 1, 2);
    chk("R5 illegal opcode enters as NOP", int'(stage_opc[1:0]), 0);
    flush();
    chk("R5 registers untouched", int'(reg_view), 'o0361);

    // R4: NOPs with arbitrary indices do nothing
    snap = int'(reg_view);
    issue(0, 1, 2, 3);
    issue(0, 3, 3, 0);
    issue(0, 2, 0, 1);
    chk("R4 NOPs keep registers", int'(reg_view), snap);

    // R6 / R10: disjoint accepted, overlapping blocked
    issue(1, 0, 0, 0);
    issue(2, 1, 2, 3);
    chk("R10 disjoint SUB admitted", int'(stage_opc[1:0]), 2);
    issue(1, 3, 1, 1);
    chk("R6 overlap with two in flight", int'(stage_opc[1:0]), 0);
    issue(1, 0, 3, 2);
    chk("R6 overlap with stage3", int'(stage_opc[1:0]), 0);
    flush();
    chk("R6 r0 from accepted ADD", reg_of(0), 2);
    chk("R6 r3 from accepted SUB", reg_of(3), 3);

    // R6: shared source alone is a conflict
    issue(1, 2, 2, 0);
    issue(1, 2, 1, 3);
    chk("R6 shared source blocked", int'(stage_opc[1:0]), 0);
    flush();
    chk("R6 r0 = 3+3", reg_of(0), 6);

    // R8: reuse distance of four steps
    issue(1, 1, 1, 1);
    issue(0, 0, 0, 0);
    issue(0, 0, 0, 0);
    issue(1, 1, 1, 1);
    chk("R8 blocked at k+3", int'(stage_opc[1:0]), 0);
    issue(1, 1, 1, 1);
    chk("R8 admitted at k+4", int'(stage_opc[1:0]), 1);
    flush();
    chk("R8 r1 = 4+4 wraps", reg_of(1), 0);

    // R10: four disjoint operations back to back
    issue(1, 0, 0, 0);
    issue(2, 1, 1, 1);
    issue(1, 2, 2, 2);
    issue(2, 3, 3, 3);
    chk("R10 back-to-back stages", int'(stage_opc), 6'b10_01_10);
    flush();

    // Sweeps over every operation encoding in three orderings (R2 R3 R6 R9)
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 256; i++) begin
        int mult;
        int v;
        mult = (p == 0) ? 1 : ((p == 1) ? 37 : 101);
        v = (i * mult + p * 11) % 256;
        issue(v >> 6, (v >> 4) & 3, (v >> 2) & 3, v & 3);
      end
      flush();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule